// File: doc/BRIEF.md
# Reserved-Word Atomic Sequencer

This block carries out the word-sized atomic memory operations of a single processor core, using physical addresses that have already been translated. It holds one address reservation. A load-reserved operation sets the reservation, and a later store-conditional operation consults it. The block also runs every read-modify-write atomic as two memory cycles: first a load, then a store of a value computed from the old word and the register operand. It reports back one result per request: a destination write, a fault code, or nothing to write.

The core hands over one request at a time on the request port. The request carries an operation code, the width field, the rs2 register index and value, and the physical address. Ordinary stores that the core performs elsewhere are shown to the block on a separate snoop port, so that they can cancel the reservation. The memory side is a single-outstanding request/response pair. The response returns a data word and an error flag.

Top module: `amo_resv_unit`

## Requirements
- R1: After reset no reservation is held, so a store-conditional issued before any load-reserved fails.
- R2: A load-reserved returns the memory word to the destination. It records its address as the reservation only when the load completes without error. A newer load-reserved replaces an older reservation.
- R3: A store-conditional whose word address equals the held reservation writes rs2 to memory, returns 0 to the destination and drops the reservation. A second store-conditional to the same address then fails.
- R4: A failed store-conditional issues no memory write, returns 1 to the destination and leaves the reservation as it was.
- R5: A snooped ordinary store cancels a held reservation when the two addresses agree with their two lowest bits ignored. A store to any other word leaves the reservation in place.
- R6: A load-reserved with nonzero low two address bits faults with code 2. A store-conditional with such an address faults with code 3. Neither operation touches memory.
- R7: Fault code 1 (illegal) is raised for a width field other than 3'b010, for an operation code of 11 or above, and for a load-reserved with a nonzero rs2 index. The checks apply in this order: width first, then operation code, then misalignment, then the rs2 index.
- R8: Operation codes are 0 load-reserved, 1 store-conditional, 2 swap, 3 add, 4 xor, 5 and, 6 or, 7 signed min, 8 signed max, 9 unsigned min, 10 unsigned max. For codes 2 to 10 the old word goes to the destination, and the operation applied to the old word and rs2 is stored to the same address.
- R9: A load that returns an error ends the operation with fault code 4. No store is issued and the destination is not written.
- R10: A store that returns an error ends the operation with fault code 5 and no destination write. An atomic's own successful store cancels a reservation on the same word, as an ordinary store does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 4 | Operation code (R8) |
| req_width | input | 3 | Access width field; word is 3'b010 |
| req_rs2_idx | input | 5 | rs2 register index |
| req_addr | input | AW | Physical address |
| req_rs2_data | input | DW | rs2 operand value |
| snoop_st_valid | input | 1 | Ordinary store seen by the core |
| snoop_st_addr | input | AW | Address of that ordinary store |
| mem_req | output | 1 | Memory cycle request pulse |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_err | input | 1 | Memory response carries an error |
| mem_rdata | input | DW | Memory read data |
| rsp_valid | output | 1 | Operation finished (one-cycle pulse) |
| rsp_rd_we | output | 1 | Destination register to be written |
| rsp_rd_data | output | DW | Destination value |
| rsp_fault | output | 3 | 0 none, 1 illegal, 2 load misaligned, 3 store misaligned, 4 load error, 5 store error |

## Verification
Because the reservation is hidden state, an error in it appears at the ports only when the next store-conditional runs. A reservation wrongly kept or wrongly dropped shows up as a 0/1 swap on the destination, and as a memory write that appears or goes missing in that same operation. The bench therefore follows each load-reserved, snoop and atomic with a store-conditional, which exposes the reservation within one operation. A wrong sequencing state shows up within a few cycles as a missing or extra memory pulse, or as a wrong fault code.

// File: rtl/amo_resv_pkg.sv
package amo_resv_pkg;

  localparam logic [3:0] OP_LR   = 4'd0;
  localparam logic [3:0] OP_SC   = 4'd1;
  localparam logic [3:0] OP_SWAP = 4'd2;
  localparam logic [3:0] OP_ADD  = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_AND  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_MIN  = 4'd7;
  localparam logic [3:0] OP_MAX  = 4'd8;
  localparam logic [3:0] OP_MINU = 4'd9;
  localparam logic [3:0] OP_MAXU = 4'd10;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ILLEGAL = 3'd1,
    FLT_LD_MIS  = 3'd2,
    FLT_ST_MIS  = 3'd3,
    FLT_LD_ACC  = 3'd4,
    FLT_ST_ACC  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LOAD  = 2'd1,
    S_STORE = 2'd2
  } state_e;

endpackage

// File: rtl/amo_resv_decode.sv
module amo_resv_decode
  import amo_resv_pkg::*;
#(
  parameter int          OFS       = 2,
  parameter logic [2:0]  WORD_CODE = 3'b010
) (
  input  logic [3:0]     op,
  input  logic [2:0]     width,
  input  logic [4:0]     rs2_idx,
  input  logic [OFS-1:0] addr_lo,
  output fault_e         fault
);

  logic misaligned;
  assign misaligned = (addr_lo != '0);

  always_comb begin
    fault = FLT_NONE;
    if (width != WORD_CODE) begin
      fault = FLT_ILLEGAL;
    end else if (op > OP_MAXU) begin
      fault = FLT_ILLEGAL;
    end else if (op == OP_LR) begin
      if (misaligned)
        fault = FLT_LD_MIS;
      else if (rs2_idx != 5'd0)
        fault = FLT_ILLEGAL;
    end else if (op == OP_SC) begin
      if (misaligned)
        fault = FLT_ST_MIS;
    end
  end

endmodule

// File: rtl/amo_resv_alu.sv
module amo_resv_alu
  import amo_resv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] opnd,
  output logic [DW-1:0] result
);

  logic s_lt;
  logic u_lt;

  assign s_lt = ($signed(old_val) < $signed(opnd));
  assign u_lt = (old_val < opnd);

  always_comb begin
    unique case (op)
      OP_ADD:  result = old_val + opnd;
      OP_XOR:  result = old_val ^ opnd;
      OP_AND:  result = old_val & opnd;
      OP_OR:   result = old_val | opnd;
      OP_MIN:  result = s_lt ? old_val : opnd;
      OP_MAX:  result = s_lt ? opnd : old_val;
      OP_MINU: result = u_lt ? old_val : opnd;
      OP_MAXU: result = u_lt ? opnd : old_val;
      default: result = opnd;
    endcase
  end

endmodule

// File: rtl/amo_resv_reg.sv
module amo_resv_reg #(
  parameter int AW   = 32,
  parameter int OFS  = 2,
  parameter int NCLR = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         set_en,
  input  logic [AW-1:0]                set_val,
  input  logic                         kill_en,
  input  logic [NCLR-1:0]              clr_en,
  input  logic [NCLR-1:0][AW-OFS-1:0]  clr_word,
  input  logic [AW-1:0]                query_val,
  output logic                         hit
);

  logic [AW-1:0]   resv_q;
  logic [NCLR-1:0] clr_hit;

  for (genvar i = 0; i < NCLR; i++) begin : g_clr
    assign clr_hit[i] = clr_en[i] && resv_q[0] && (resv_q[AW-1:OFS] == clr_word[i]);
  end

  assign hit = (resv_q == query_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_q <= '0;
    end else if (set_en) begin
      resv_q <= set_val;
    end else if (kill_en || (|clr_hit)) begin
      resv_q <= '0;
    end
  end

  // R1
  resv_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !resv_q[0]);

  // R2
  resv_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |=> (resv_q == $past(set_val)) && resv_q[0]);

endmodule

// File: rtl/amo_resv_unit.sv
module amo_resv_unit
  import amo_resv_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter logic [2:0]  WORD_CODE = 3'b010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_op,
  input  logic [2:0]    req_width,
  input  logic [4:0]    req_rs2_idx,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_rs2_data,
  input  logic          snoop_st_valid,
  input  logic [AW-1:0] snoop_st_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rsp_valid,
  input  logic          mem_rsp_err,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic          rsp_rd_we,
  output logic [DW-1:0] rsp_rd_data,
  output logic [2:0]    rsp_fault
);

  localparam int OFS  = $clog2(DW / 8);
  localparam int NCLR = 2;

  state_e        state_q;
  logic [3:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rs2_q;
  logic [DW-1:0] old_q;

  fault_e        dec_fault;
  logic [DW-1:0] alu_res;
  logic          sc_hit;
  logic          load_ok;
  logic          store_ok;

  logic                        resv_set;
  logic                        resv_kill;
  logic [NCLR-1:0]             clr_en;
  logic [NCLR-1:0][AW-OFS-1:0] clr_word;

  assign req_ready = (state_q == S_IDLE);
  assign load_ok   = (state_q == S_LOAD)  && mem_rsp_valid && !mem_rsp_err;
  assign store_ok  = (state_q == S_STORE) && mem_rsp_valid && !mem_rsp_err;

  amo_resv_decode #(
    .OFS       (OFS),
    .WORD_CODE (WORD_CODE)
  ) u_decode (
    .op      (req_op),
    .width   (req_width),
    .rs2_idx (req_rs2_idx),
    .addr_lo (req_addr[OFS-1:0]),
    .fault   (dec_fault)
  );

  amo_resv_alu #(
    .DW (DW)
  ) u_alu (
    .op      (op_q),
    .old_val (mem_rdata),
    .opnd    (rs2_q),
    .result  (alu_res)
  );

  assign resv_set    = load_ok && (op_q == OP_LR);
  assign resv_kill   = store_ok && (op_q == OP_SC);
  assign clr_en[0]   = snoop_st_valid;
  assign clr_word[0] = snoop_st_addr[AW-1:OFS];
  assign clr_en[1]   = store_ok && (op_q != OP_SC);
  assign clr_word[1] = addr_q[AW-1:OFS];

  amo_resv_reg #(
    .AW   (AW),
    .OFS  (OFS),
    .NCLR (NCLR)
  ) u_resv (
    .clk       (clk),
    .rst       (rst),
    .set_en    (resv_set),
    .set_val   ({addr_q[AW-1:1], 1'b1}),
    .kill_en   (resv_kill),
    .clr_en    (clr_en),
    .clr_word  (clr_word),
    .query_val ({req_addr[AW-1:1], 1'b1}),
    .hit       (sc_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      op_q        <= '0;
      addr_q      <= '0;
      rs2_q       <= '0;
      old_q       <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      rsp_valid   <= 1'b0;
      rsp_rd_we   <= 1'b0;
      rsp_rd_data <= '0;
      rsp_fault   <= FLT_NONE;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rd_we <= 1'b0;
      rsp_fault <= FLT_NONE;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            rs2_q  <= req_rs2_data;
            if (dec_fault != FLT_NONE) begin
              rsp_valid <= 1'b1;
              rsp_fault <= dec_fault;
            end else if (req_op == OP_SC) begin
              if (sc_hit) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= req_addr;
                mem_wdata <= req_rs2_data;
                state_q   <= S_STORE;
              end else begin
                rsp_valid   <= 1'b1;
                rsp_rd_we   <= 1'b1;
                rsp_rd_data <= DW'(1);
              end
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= req_addr;
              state_q  <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              rsp_valid <= 1'b1;
              rsp_fault <= FLT_LD_ACC;
              state_q   <= S_IDLE;
            end else if (op_q == OP_LR) begin
              rsp_valid   <= 1'b1;
              rsp_rd_we   <= 1'b1;
              rsp_rd_data <= mem_rdata;
              state_q     <= S_IDLE;
            end else begin
              old_q     <= mem_rdata;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= addr_q;
              mem_wdata <= alu_res;
              state_q   <= S_STORE;
            end
          end
        end
        S_STORE: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            state_q   <= S_IDLE;
            if (mem_rsp_err) begin
              rsp_fault <= FLT_ST_ACC;
            end else begin
              rsp_rd_we   <= 1'b1;
              rsp_rd_data <= (op_q == OP_SC) ? '0 : old_q;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  load_err_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_LOAD) && mem_rsp_valid && mem_rsp_err) |=> !mem_req);

  // R4
  sc_miss_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == S_IDLE) && req_valid && (dec_fault == FLT_NONE) &&
     (req_op == OP_SC) && !sc_hit) |=> !mem_req && rsp_valid && (rsp_rd_data == DW'(1)));

  // R10
  fault_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault != FLT_NONE)) |-> !rsp_rd_we);

  // R8
  maxu_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (load_ok && (op_q == OP_MAXU)) |=>
      mem_req && mem_we && (mem_wdata >= $past(mem_rdata)) && (mem_wdata >= rs2_q));

endmodule

// File: tb/amo_resv_unit_tb.sv
module amo_resv_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [2:0]  req_width = 3'b010;
  logic [4:0]  req_rs2_idx = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_rs2_data = '0;
  logic        snoop_st_valid = 1'b0;
  logic [31:0] snoop_st_addr = '0;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_rd_we;
  logic [31:0] rsp_rd_data;
  logic [2:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  int store_cnt = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [31:0] mem [0:15];

  always #4 clk = ~clk;

  amo_resv_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_width(req_width), .req_rs2_idx(req_rs2_idx),
    .req_addr(req_addr), .req_rs2_data(req_rs2_data),
    .snoop_st_valid(snoop_st_valid), .snoop_st_addr(snoop_st_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_rd_we(rsp_rd_we), .rsp_rd_data(rsp_rd_data),
    .rsp_fault(rsp_fault)
  );

  // memory model: region F faults on all accesses, region E faults on writes only
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (mem_req) begin
      logic bad;
      bad = (mem_addr[31:28] == 4'hF) || ((mem_addr[31:28] == 4'hE) && mem_we);
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= bad;
      mem_rdata     <= (mem_addr[31:28] == 4'hE) ? 32'd0 : mem[mem_addr[5:2]];
      if (mem_we && !bad) begin
        mem[mem_addr[5:2]] <= mem_wdata;
        store_cnt = store_cnt + 1;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [2:0] w, input logic [4:0] r2,
                       input logic [31:0] a, input logic [31:0] d,
                       output logic [2:0] f, output logic we, output logic [31:0] rd);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_width = w; req_rs2_idx = r2;
    req_addr = a; req_rs2_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 50) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL response timeout: actual=none expected=rsp_valid");
    end
    f = rsp_fault; we = rsp_rd_we; rd = rsp_rd_data;
  endtask

  task automatic snoop(input logic [31:0] a);
    @(negedge clk);
    snoop_st_valid = 1'b1; snoop_st_addr = a;
    @(negedge clk);
    snoop_st_valid = 1'b0;
  endtask

  function automatic logic [31:0] amo_ref(input logic [3:0] op, input logic [31:0] o, input logic [31:0] b);
    case (op)
      4'd2:  return b;
      4'd3:  return o + b;
      4'd4:  return o ^ b;
      4'd5:  return o & b;
      4'd6:  return o | b;
      4'd7:  return ($signed(o) <= $signed(b)) ? o : b;
      4'd8:  return ($signed(o) >= $signed(b)) ? o : b;
      4'd9:  return (o <= b) ? o : b;
      default: return (o >= b) ? o : b;
    endcase
  endfunction

  logic [2:0]  f;
  logic        we;
  logic [31:0] rd;

  task automatic t_reset_state();
    int sc0;
    chk(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
    sc0 = store_cnt;
    do_op(4'd1, 3'b010, 5'd0, 32'h10, 32'hAAAA, f, we, rd);
    chk(we && rd == 32'd1 && f == 3'd0, "R1 sc after reset fails", rd, 32'd1);
    chk(store_cnt == sc0, "R1 no write", store_cnt, sc0);
  endtask

  task automatic t_lr_sc();
    do_op(4'd0, 3'b010, 5'd0, 32'h10, 32'h0, f, we, rd);
    chk(we && rd == mem[4] && f == 3'd0, "R2 lr data", rd, mem[4]);
    do_op(4'd1, 3'b010, 5'd0, 32'h10, 32'h1234_5678, f, we, rd);
    chk(we && rd == 32'd0, "R3 sc success rd", rd, 32'd0);
    chk(mem[4] == 32'h1234_5678, "R3 sc wrote", mem[4], 32'h1234_5678);
    do_op(4'd1, 3'b010, 5'd0, 32'h10, 32'h5555, f, we, rd);
    chk(we && rd == 32'd1, "R3 reservation dropped", rd, 32'd1);
    chk(mem[4] == 32'h1234_5678, "R4 failed sc no write", mem[4], 32'h1234_5678);
  endtask

  task automatic t_replace_and_keep();
    do_op(4'd0, 3'b010, 5'd0, 32'h18, 32'h0, f, we, rd);
    do_op(4'd0, 3'b010, 5'd0, 32'h1C, 32'h0, f, we, rd);
    do_op(4'd1, 3'b010, 5'd0, 32'h18, 32'h77, f, we, rd);
    chk(rd == 32'd1 && mem[6] != 32'h77, "R2 older reservation replaced", rd, 32'd1);
    do_op(4'd1, 3'b010, 5'd0, 32'h1C, 32'h88, f, we, rd);
    chk(rd == 32'd0 && mem[7] == 32'h88, "R4 reservation kept after failed sc", rd, 32'd0);
  endtask

  task automatic t_snoop();
    do_op(4'd0, 3'b010, 5'd0, 32'h20, 32'h0, f, we, rd);
    snoop(32'h22);
    do_op(4'd1, 3'b010, 5'd0, 32'h20, 32'h99, f, we, rd);
    chk(rd == 32'd1 && mem[8] != 32'h99, "R5 same-word snoop cancels", rd, 32'd1);
    do_op(4'd0, 3'b010, 5'd0, 32'h20, 32'h0, f, we, rd);
    snoop(32'h24);
    do_op(4'd1, 3'b010, 5'd0, 32'h20, 32'h99, f, we, rd);
    chk(rd == 32'd0 && mem[8] == 32'h99, "R5 other-word snoop ignored", rd, 32'd0);
  endtask

  task automatic t_faults();
    int sc0;
    sc0 = store_cnt;
    do_op(4'd0, 3'b010, 5'd0, 32'h11, 32'h0, f, we, rd);
    chk(f == 3'd2 && !we, "R6 lr misaligned", {29'd0, f}, 32'd2);
    do_op(4'd1, 3'b010, 5'd0, 32'h12, 32'h0, f, we, rd);
    chk(f == 3'd3 && !we, "R6 sc misaligned", {29'd0, f}, 32'd3);
    chk(store_cnt == sc0, "R6 no memory write", store_cnt, sc0);
    do_op(4'd0, 3'b010, 5'd3, 32'h10, 32'h0, f, we, rd);
    chk(f == 3'd1 && !we, "R7 lr rs2 nonzero", {29'd0, f}, 32'd1);
    do_op(4'd0, 3'b010, 5'd3, 32'h13, 32'h0, f, we, rd);
    chk(f == 3'd2, "R7 misalign before rs2", {29'd0, f}, 32'd2);
    do_op(4'd0, 3'b011, 5'd0, 32'h11, 32'h0, f, we, rd);
    chk(f == 3'd1, "R7 width first", {29'd0, f}, 32'd1);
    do_op(4'd12, 3'b010, 5'd0, 32'h10, 32'h0, f, we, rd);
    chk(f == 3'd1, "R7 undefined op", {29'd0, f}, 32'd1);
    do_op(4'd3, 3'b000, 5'd0, 32'h10, 32'h1, f, we, rd);
    chk(f == 3'd1 && store_cnt == sc0, "R7 amo byte width", {29'd0, f}, 32'd1);
  endtask

  task automatic t_amo(input logic [31:0] o, input logic [31:0] b);
    for (int op = 2; op <= 10; op++) begin
      logic [31:0] e;
      mem[5] = o;
      e = amo_ref(4'(op), o, b);
      do_op(4'(op), 3'b010, 5'd0, 32'h14, b, f, we, rd);
      chk(we && rd == o && f == 3'd0, $sformatf("R8 op%0d old value", op), rd, o);
      chk(mem[5] == e, $sformatf("R8 op%0d stored", op), mem[5], e);
    end
  endtask

  task automatic t_bus_errors();
    int sc0;
    do_op(4'd0, 3'b010, 5'd0, 32'h30, 32'h0, f, we, rd);
    sc0 = store_cnt;
    do_op(4'd3, 3'b010, 5'd0, 32'hF000_0030, 32'h5, f, we, rd);
    chk(f == 3'd4 && !we && store_cnt == sc0, "R9 amo load error", {29'd0, f}, 32'd4);
    do_op(4'd0, 3'b010, 5'd0, 32'hF000_0030, 32'h0, f, we, rd);
    chk(f == 3'd4 && !we, "R9 lr load error", {29'd0, f}, 32'd4);
    do_op(4'd1, 3'b010, 5'd0, 32'h30, 32'h3C3C, f, we, rd);
    chk(rd == 32'd0 && mem[12] == 32'h3C3C, "R2 failed lr keeps old reservation", rd, 32'd0);
    do_op(4'd0, 3'b010, 5'd0, 32'hE000_0000, 32'h0, f, we, rd);
    do_op(4'd1, 3'b010, 5'd0, 32'hE000_0000, 32'h1, f, we, rd);
    chk(f == 3'd5 && !we, "R10 sc store error", {29'd0, f}, 32'd5);
    do_op(4'd2, 3'b010, 5'd0, 32'hE000_0004, 32'h1, f, we, rd);
    chk(f == 3'd5 && !we, "R10 amo store error", {29'd0, f}, 32'd5);
  endtask

  task automatic t_amo_clears();
    do_op(4'd0, 3'b010, 5'd0, 32'h08, 32'h0, f, we, rd);
    do_op(4'd3, 3'b010, 5'd0, 32'h08, 32'h1, f, we, rd);
    do_op(4'd1, 3'b010, 5'd0, 32'h08, 32'hBEEF, f, we, rd);
    chk(rd == 32'd1 && mem[2] != 32'hBEEF, "R10 amo store cancels reservation", rd, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0100_0000 + i * 32'h111;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_lr_sc();
    t_replace_and_keep();
    t_snoop();
    t_faults();
    t_amo(32'hFFFF_FFF0, 32'h0000_0007);
    t_amo(32'h0000_0005, 32'h8000_0000);
    t_bus_errors();
    t_amo_clears();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule